// File: doc/BRIEF.md
# Hoisted Load Alias Guard Table

This block lets a compiler move a load above earlier stores that might write the same bytes. When a hoisted ("advanced") load runs, it registers its destination register, byte address and access size in a small associative table. Every store that runs afterwards is compared against all live entries, and any entry whose bytes overlap the store's bytes is dropped. When the program later reaches the point where the load originally sat, it issues a check on the destination register. If the entry is still live, no store touched the loaded bytes and the check does nothing. Otherwise the check reports that the value must be fetched again, or, in the branching form, that control must divert to recovery code.

Entries are looked up by register tag and killed by address. A register has at most one live entry. A new hoisted load to a register that already has a live entry reuses that entry. Otherwise the lowest-numbered free entry is used, and when every entry is live a round-robin victim is replaced. A check cannot tell an evicted entry from an aliased one, and both give the same miss.

The three input ports take one request each per cycle and are never stalled, so they carry a valid strobe and no ready. The response port is a one-cycle pulse with no back-pressure: a response appears exactly one clock after its check and must be consumed in that cycle. Within one cycle the store is applied first, then the check looks up the table, then the allocation is written.

Top module: `hoist_guard_table`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low, and a check on any register misses.
- R2: A check issued in cycle N raises `rsp_valid` in cycle N+1 with `rsp_reg` equal to the checked register. A check on a register with a live entry returns `rsp_kind` 2'b00 (no-op) with `rsp_addr` zero. `rsp_valid` is low in cycles after cycles with no check.
- R3: A check that hits leaves its entry live, so a repeated check on the same register hits again.
- R4: A store covering bytes [addr, addr + 2^size) kills every live entry whose range [addr, addr + 2^size) overlaps it, partial overlap included. A store that only touches adjacent bytes leaves the entry live.
- R5: A non-branching check that finds no live entry returns `rsp_kind` 2'b01 (reload) and `rsp_addr` equal to the check's `ck_addr`.
- R6: A branching check (`ck_branch` high) that finds no live entry returns `rsp_kind` 2'b10 (branch to recovery) with `rsp_addr` zero. `rsp_kind` is never 2'b11.
- R7: A hoisted load to a register that already has a live entry overwrites that entry. From then on only stores overlapping the new range kill it.
- R8: A hoisted load with no live entry for its register takes the lowest-numbered invalid entry. When all ENTRIES entries are live, it replaces a victim chosen round robin: entry 0 first after reset, then 1, and so on. A check on an evicted register misses.
- R9: When a store and a check arrive in the same cycle, the check sees the table after the store's invalidation.
- R10: When a hoisted load and an overlapping store arrive in the same cycle, the new entry is written after the invalidation and stays live.
- R11: When a hoisted load and a check on the same register arrive in the same cycle, the check sees the table before the new entry is written.
- R12: One store kills every overlapping entry at once, however many there are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| al_valid | input | 1 | Hoisted load registers an entry this cycle |
| al_reg | input | 5 | Destination register tag of the hoisted load |
| al_addr | input | 32 | Byte address of the hoisted load |
| al_size | input | 3 | log2 of the hoisted load's byte count |
| st_valid | input | 1 | Store snoop this cycle |
| st_addr | input | 32 | Byte address of the store |
| st_size | input | 3 | log2 of the store's byte count |
| ck_valid | input | 1 | Check request this cycle |
| ck_reg | input | 5 | Register tag being checked |
| ck_addr | input | 32 | Address of the checked load, returned on a reload |
| ck_branch | input | 1 | 1 = branching check form, 0 = reloading form |
| rsp_valid | output | 1 | Response pulse, one cycle after a check |
| rsp_kind | output | 2 | 00 no-op, 01 reload, 10 branch to recovery |
| rsp_reg | output | 5 | Register tag of the answered check |
| rsp_addr | output | 32 | Address to re-fetch on reload, else zero |

## Verification
Directed sequences cover each ordering case one at a time. A store on the byte just past an entry and a store one byte into it separate a correct overlap test from an exact-address compare or an off-by-one. Store with check, load with store, and load with check in the same cycle each show which side of the same edge the table state is taken from. Filling all sixteen entries and adding two more registers tells round-robin replacement apart from first-free or fixed-slot replacement. A long random run then uses more register tags than there are entries and a narrow address window, so overwrites, eviction and multi-entry kills are mixed freely, and each response is compared with a reference model built from the requirements.

// File: rtl/hgt_pkg.sv
package hgt_pkg;
  localparam int REG_W_DEF  = 5;
  localparam int ADDR_W_DEF = 32;
  localparam int SZ_W_DEF   = 3;

  typedef enum logic [1:0] {
    RSP_NOOP   = 2'b00,
    RSP_RELOAD = 2'b01,
    RSP_BRANCH = 2'b10
  } rsp_kind_e;
endpackage

// File: rtl/hgt_overlap.sv
// Byte-range overlap between a table entry and a store.
module hgt_overlap #(
  parameter int ADDR_W = 32,
  parameter int SZ_W   = 3
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [SZ_W-1:0]   a_lsz,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [SZ_W-1:0]   b_lsz,
  output logic              hit
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] a_lo, b_lo, a_end, b_end;

  always_comb begin
    a_lo  = {1'b0, a_addr};
    b_lo  = {1'b0, b_addr};
    a_end = a_lo + (EW'(1) << a_lsz);
    b_end = b_lo + (EW'(1) << b_lsz);
    hit   = (a_lo < b_end) && (b_lo < a_end);
  end
endmodule

// File: rtl/hgt_alloc_pick.sv
// Chooses the entry a hoisted load writes: same tag, else first free,
// else the round-robin victim.
module hgt_alloc_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               al_valid,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] tag_hit,
  output logic [IDX_W-1:0]   wr_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] tag_idx, free_idx;
  logic             tag_any, free_any, use_victim;

  always_comb begin
    tag_idx  = '0;
    tag_any  = 1'b0;
    free_idx = '0;
    free_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (tag_hit[i] && !tag_any) begin
        tag_idx = IDX_W'(i);
        tag_any = 1'b1;
      end
      if (!live[i] && !free_any) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
    if (tag_any)       wr_idx = tag_idx;
    else if (free_any) wr_idx = free_idx;
    else               wr_idx = rr_q;
    use_victim = al_valid && !tag_any && !free_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (use_victim) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R7: a register never owns more than one live entry.
  assert_one_entry_per_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tag_hit));

  // R8: a victim is only replaced when every entry is live.
  assert_victim_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (al_valid && !(|tag_hit) && !(&live)) |=> $stable(rr_q));
endmodule

// File: rtl/hoist_guard_table.sv
module hoist_guard_table
  import hgt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int REG_W   = REG_W_DEF,
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int SZ_W    = SZ_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              al_valid,
  input  logic [REG_W-1:0]  al_reg,
  input  logic [ADDR_W-1:0] al_addr,
  input  logic [SZ_W-1:0]   al_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SZ_W-1:0]   st_size,
  input  logic              ck_valid,
  input  logic [REG_W-1:0]  ck_reg,
  input  logic [ADDR_W-1:0] ck_addr,
  input  logic              ck_branch,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [REG_W-1:0]  rsp_reg,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, ovl, kill, vld_mid, al_tag_hit, ck_tag_hit;
  logic [REG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [SZ_W-1:0]    lsz_q  [ENTRIES];
  logic [IDX_W-1:0]   wr_idx;
  logic               ck_found;
  rsp_kind_e          kind_d;

  // Store invalidation comes first; check and allocation see its result.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    hgt_overlap #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_ovl (
      .a_addr (addr_q[e]),
      .a_lsz  (lsz_q[e]),
      .b_addr (st_addr),
      .b_lsz  (st_size),
      .hit    (ovl[e])
    );
    assign kill[e]       = st_valid && vld_q[e] && ovl[e];
    assign vld_mid[e]    = vld_q[e] && !kill[e];
    assign al_tag_hit[e] = vld_mid[e] && (tag_q[e] == al_reg);
    assign ck_tag_hit[e] = vld_mid[e] && (tag_q[e] == ck_reg);
  end

  hgt_alloc_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .al_valid (al_valid),
    .live     (vld_mid),
    .tag_hit  (al_tag_hit),
    .wr_idx   (wr_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_mid;
      if (al_valid) vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (al_valid) begin
      tag_q[wr_idx]  <= al_reg;
      addr_q[wr_idx] <= al_addr;
      lsz_q[wr_idx]  <= al_size;
    end
  end

  // Check lookup and registered response.
  always_comb begin
    ck_found = |ck_tag_hit;
    if (ck_found)       kind_d = RSP_NOOP;
    else if (ck_branch) kind_d = RSP_BRANCH;
    else                kind_d = RSP_RELOAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= RSP_NOOP;
      rsp_reg   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= ck_valid;
      if (ck_valid) begin
        rsp_kind <= kind_d;
        rsp_reg  <= ck_reg;
        rsp_addr <= (kind_d == RSP_RELOAD) ? ck_addr : '0;
      end
    end
  end

  // Assertion support: remember the last allocation.
  logic             al_pend_q;
  logic [REG_W-1:0] al_reg_q;
  logic             landed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_pend_q <= 1'b0;
      al_reg_q  <= '0;
    end else begin
      al_pend_q <= al_valid;
      al_reg_q  <= al_reg;
    end
  end

  always_comb begin
    landed = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld_q[i] && tag_q[i] == al_reg_q) landed = 1'b1;
  end

  assert_rsp_follows_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ck_valid |=> (rsp_valid && rsp_reg == $past(ck_reg)));

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_valid |=> !rsp_valid);

  // R10: a new entry is live after its write, even beside a store.
  assert_alloc_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    al_pend_q |-> landed);

  assert_store_kills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && (|kill) && !al_valid) |=> ($countones(vld_q) < $past($countones(vld_q))));

  assert_kind_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'b11));

  assert_branch_addr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b10) |-> (rsp_addr == '0));
endmodule

// File: tb/hoist_guard_table_tb_top.sv
`timescale 1ns/1ps
module hoist_guard_table_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        al_valid = 0, st_valid = 0, ck_valid = 0, ck_branch = 0;
  logic [4:0]  al_reg = 0, ck_reg = 0;
  logic [31:0] al_addr = 0, st_addr = 0, ck_addr = 0;
  logic [2:0]  al_size = 0, st_size = 0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [4:0]  rsp_reg;
  logic [31:0] rsp_addr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hoist_guard_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .al_valid(al_valid), .al_reg(al_reg), .al_addr(al_addr), .al_size(al_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .ck_valid(ck_valid), .ck_reg(ck_reg), .ck_addr(ck_addr), .ck_branch(ck_branch),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_reg(rsp_reg), .rsp_addr(rsp_addr)
  );

  // Reference model of the table.
  bit          m_vld [N];
  logic [4:0]  m_tag [N];
  logic [31:0] m_adr [N];
  logic [2:0]  m_lsz [N];
  int          m_rr;

  function automatic bit ovl(logic [31:0] a, logic [2:0] sa, logic [31:0] b, logic [2:0] sb);
    longint unsigned alo = a, blo = b;
    return (alo < blo + (64'd1 << sb)) && (blo < alo + (64'd1 << sa));
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_rr = 0;
  endfunction

  // Store, then check, then allocate; returns the expected response kind.
  function automatic logic [1:0] m_step(
      bit al, logic [4:0] ar, logic [31:0] aa, logic [2:0] as,
      bit st, logic [31:0] sa, logic [2:0] ss,
      logic [4:0] cr, bit cb);
    bit found = 0;
    int w = -1;
    logic [1:0] k;
    if (st)
      for (int i = 0; i < N; i++)
        if (m_vld[i] && ovl(m_adr[i], m_lsz[i], sa, ss)) m_vld[i] = 0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_tag[i] == cr) found = 1;
    k = found ? 2'b00 : (cb ? 2'b10 : 2'b01);
    if (al) begin
      for (int i = 0; i < N; i++)
        if (w < 0 && m_vld[i] && m_tag[i] == ar) w = i;
      for (int i = 0; i < N; i++)
        if (w < 0 && !m_vld[i]) w = i;
      if (w < 0) begin
        w = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_vld[w] = 1; m_tag[w] = ar; m_adr[w] = aa; m_lsz[w] = as;
    end
    return k;
  endfunction

  task automatic cyc(bit al, logic [4:0] ar, logic [31:0] aa, logic [2:0] as,
                     bit st, logic [31:0] sa, logic [2:0] ss,
                     bit ck, logic [4:0] cr, logic [31:0] ca, bit cb, string req);
    logic [1:0]  ek;
    logic [31:0] ea;
    al_valid = al; al_reg = ar; al_addr = aa; al_size = as;
    st_valid = st; st_addr = sa; st_size = ss;
    ck_valid = ck; ck_reg = cr; ck_addr = ca; ck_branch = cb;
    ek = m_step(al, ar, aa, as, st, sa, ss, cr, cb);
    if (!ck) ek = 2'b00;
    ea = (ek == 2'b01) ? ca : 32'd0;
    @(posedge clk); #1;
    tests++;
    if (ck) begin
      if (rsp_valid !== 1'b1 || rsp_kind !== ek || rsp_reg !== cr || rsp_addr !== ea) begin
        fails++;
        $display("FAIL %s: valid/kind/reg/addr got %0b/%0d/%0d/%h expected 1/%0d/%0d/%h",
                 req, rsp_valid, rsp_kind, rsp_reg, rsp_addr, ek, cr, ea);
      end
    end else if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s: rsp_valid got %0b expected 0", req, rsp_valid);
    end
  endtask

  task automatic idle(string req);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic do_reset();
    al_valid = 0; st_valid = 0; ck_valid = 0;
    rst_n = 0;
    m_clear();
    repeat (3) @(posedge clk);
    #1;
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid in reset got %0b expected 0", rsp_valid);
    end
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed = 7321;
    void'($urandom(seed));
    do_reset();
    // R1: empty table misses.
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd3, 32'h0000_0300, 0, "R1");
    idle("R2");
    // R2, R3: hit and repeated hit.
    cyc(1, 5'd5, 32'h1000, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd5, 32'h1000, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd5, 32'h1000, 0, "R3");
    // R4: adjacent store keeps, one-byte partial overlap kills.
    cyc(0, 0, 0, 0, 1, 32'h1004, 3'd0, 1, 5'd5, 32'h1000, 0, "R4");
    cyc(0, 0, 0, 0, 1, 32'h0FFF, 3'd0, 1, 5'd5, 32'h1000, 0, "R4");
    cyc(0, 0, 0, 0, 1, 32'h1003, 3'd1, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd5, 32'h2000, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd5, 32'h2000, 1, "R6");
    // R7: overwrite by same register.
    cyc(1, 5'd7, 32'h3000, 3'd3, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(1, 5'd7, 32'h4000, 3'd3, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 32'h3000, 3'd3, 1, 5'd7, 32'h4000, 0, "R7");
    cyc(0, 0, 0, 0, 1, 32'h4004, 3'd0, 1, 5'd7, 32'h4000, 0, "R7");
    // R9: store and check together.
    cyc(1, 5'd8, 32'h5000, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, 32'h5000, 3'd0, 1, 5'd8, 32'h5000, 0, "R9");
    // R10: allocation beside an overlapping store survives.
    cyc(1, 5'd9, 32'h6000, 3'd2, 1, 32'h6000, 3'd2, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd9, 32'h6000, 0, "R10");
    // R11: check beside allocation sees the old state.
    cyc(1, 5'd10, 32'h7000, 3'd2, 0, 0, 0, 1, 5'd10, 32'h7000, 0, "R11");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd10, 32'h7000, 0, "R11");
    // R12: one store kills two entries.
    cyc(1, 5'd11, 32'h8000, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R12");
    cyc(1, 5'd12, 32'h8004, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R12");
    cyc(0, 0, 0, 0, 1, 32'h8000, 3'd3, 1, 5'd11, 32'h8000, 1, "R12");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd12, 32'h8004, 0, "R12");
    // R8: fill, then round-robin eviction.
    do_reset();
    for (int r = 0; r < N; r++)
      cyc(1, 5'(r), 32'h9000 + 32'(r * 16), 3'd2, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 5'd16, 32'hA000, 3'd2, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 5'd17, 32'hA010, 3'd2, 0, 0, 0, 1, 5'd0, 32'h9000, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd1, 32'h9010, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd2, 32'h9020, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 5'd16, 32'hA000, 0, "R8");
    // Random mix over all requirements (R2 R4 R7 R8 R9 R12).
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 3) == 0, 5'($urandom % 24), 32'h100 + 32'($urandom % 64), 3'($urandom % 4),
          ($urandom % 4) == 0, 32'h100 + 32'($urandom % 64), 3'($urandom % 4),
          ($urandom % 2) == 0, 5'($urandom % 24), 32'h100 + 32'($urandom % 64),
          1'($urandom % 2), "R2/R4/R8 random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule